// File: doc/BRIEF.md
# Masked Alternate Address Remapper

This block decodes one programmable alternate address window for a memory controller and relocates the transactions that fall inside it. Each incoming 32-bit address is compared against a programmed base value on its upper 16 bits. A per-bit mask selects which of those bits take part in the comparison, so the window need not be a contiguous power-of-two region. When the address matches, the block raises a hit that steers the transaction to chip select zero. It also rewrites the compared bits with a programmed map value. All other address bits pass through unchanged.

Three 16-bit fields (base, mask, map) are reached through a small register port with a 2-bit select. A cold reset clears all three fields. A warm reset keeps them and holds off writes while it is asserted. A mask of all zeros turns the window off. The hit and the translated address are produced combinationally from the current fields and the input address.

Top module: `alt_remap_top`

## Requirements
- R1: Only upper address bits whose mask bit is 1 are compared with base. A hit needs every such bit to equal its base bit, and mask-0 bits are ignored.
- R2: When the mask field is all zeros the window is disabled, and hit_o stays 0 for every address and every base.
- R3: On a hit, each upper address bit with mask bit 1 is replaced by the map bit. Bits with mask bit 0, and address bits 15..0, pass through unchanged.
- R4: With no hit, addr_o equals addr_i. hit_o is the chip-select-zero steering flag.
- R5: A warm reset (warm_rst_i=1) leaves base, mask and map unchanged, and writes made while it is high are ignored.
- R6: A cold reset (rst_ni=0) clears base, mask and map to zero.
- R7: Select codes are 0=base, 1=mask, 2=map and 3=unused. A write with reg_we_i=1 loads reg_wdata_i[31:16] into the selected field at the next rising clock edge. Bits 15..0 of the write data are discarded.
- R8: reg_rdata_o returns the selected field in bits 31..16 and zeros in bits 15..0. Select 3 reads as zero, and a write to it changes no field.
- R9: hit_o and addr_o respond combinationally to addr_i, with no clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_i | input | 1 | Warm reset, registers retained, writes blocked |
| reg_sel_i | input | 2 | Field select: 0 base, 1 mask, 2 map, 3 unused |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 32 | Write data, field taken from bits 31..16 |
| reg_rdata_o | output | 32 | Read data, field in bits 31..16 |
| addr_i | input | 32 | Incoming transaction address |
| hit_o | output | 1 | Address hits the window; steer to chip select zero |
| addr_o | output | 32 | Translated address (equal to addr_i on a miss) |

## Verification
A corrupted base or mask field shows at once as a wrong hit_o for addresses that straddle the window edge. A corrupted map field shows as wrong upper bits of addr_o on the first hitting address. All of these appear in the same cycle as the address, because the path has no registers. A field that was lost or never loaded also shows on reg_rdata_o one edge after the write. Warm-reset retention is observed through readback and through the hit pattern right after the warm pulse.

// File: rtl/alt_remap_pkg.sv
package alt_remap_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned LOW_W   = ADDR_W - FIELD_W;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_MAP  = 2'd2,
    SEL_NONE = 2'd3
  } field_sel_e;

  typedef struct packed {
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] mask;
    logic [FIELD_W-1:0] map;
  } win_cfg_t;
endpackage

// File: rtl/alt_remap_regs.sv
module alt_remap_regs
  import alt_remap_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_rst_i,
  input  logic [1:0]    sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o,
  output win_cfg_t      cfg_o
);
  localparam int unsigned LW = AW - FW;

  logic [FW-1:0] wfield;
  logic          wr_ok;
  win_cfg_t      cfg_q;
  logic [FW-1:0] rfield;

  assign wfield = wdata_i[AW-1:LW];
  assign wr_ok  = we_i && !warm_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_ok) begin
      unique case (field_sel_e'(sel_i))
        SEL_BASE: cfg_q.base <= wfield;
        SEL_MASK: cfg_q.mask <= wfield;
        SEL_MAP:  cfg_q.map  <= wfield;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (field_sel_e'(sel_i))
      SEL_BASE: rfield = cfg_q.base;
      SEL_MASK: rfield = cfg_q.mask;
      SEL_MAP:  rfield = cfg_q.map;
      default:  rfield = '0;
    endcase
  end

  assign rdata_o = {rfield, {LW{1'b0}}};
  assign cfg_o   = cfg_q;

  // R5: fields hold across a warm-reset cycle
  a_r5_warm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> $stable(cfg_q));

  // R8: unused select never alters a field
  a_r8_none_sel_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_NONE) |=> $stable(cfg_q));

  // R8: low half of read data is always zero
  a_r8_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[LW-1:0] == '0);

  // R6: fields are zero while cold reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) a_r6_cold_clear: assert (cfg_q == '0);
  end
endmodule

// File: rtl/alt_remap_match.sv
module alt_remap_match
  import alt_remap_pkg::*;
#(
  parameter int unsigned FW = FIELD_W
) (
  input  logic [FW-1:0] upper_i,
  input  win_cfg_t      cfg_i,
  output logic          hit_o,
  output logic [FW-1:0] upper_o
);
  logic [FW-1:0] diff;
  logic [FW-1:0] subst;

  for (genvar b = 0; b < FW; b++) begin : g_bit
    assign diff[b]  = (upper_i[b] ^ cfg_i.base[b]) & cfg_i.mask[b];
    assign subst[b] = cfg_i.mask[b] ? cfg_i.map[b] : upper_i[b];
  end

  assign hit_o   = (|cfg_i.mask) && !(|diff);
  assign upper_o = hit_o ? subst : upper_i;
endmodule

// File: rtl/alt_remap_top.sv
module alt_remap_top
  import alt_remap_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_rst_i,
  input  logic [1:0]    reg_sel_i,
  input  logic          reg_we_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic [31:0]   addr_i,
  output logic          hit_o,
  output logic [31:0]   addr_o
);
  localparam int unsigned LW = AW - FW;

  win_cfg_t      cfg;
  logic [FW-1:0] upper_xl;

  alt_remap_regs #(.AW(AW), .FW(FW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .warm_rst_i(warm_rst_i),
    .sel_i     (reg_sel_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .cfg_o     (cfg)
  );

  alt_remap_match #(.FW(FW)) u_match (
    .upper_i(addr_i[AW-1:LW]),
    .cfg_i  (cfg),
    .hit_o  (hit_o),
    .upper_o(upper_xl)
  );

  assign addr_o = {upper_xl, addr_i[LW-1:0]};

  // R2: zero mask never hits
  a_r2_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mask == '0) |-> !hit_o);

  // R4: miss passes address through
  a_r4_miss_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (addr_o == addr_i));

  // R3: low half and masked-out upper bits never change
  a_r3_keep_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o[LW-1:0] == addr_i[LW-1:0]) &&
    ((addr_o[AW-1:LW] & ~cfg.mask) == (addr_i[AW-1:LW] & ~cfg.mask)));

  // R3: on a hit, masked-in bits carry the map value
  a_r3_hit_subst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((addr_o[AW-1:LW] & cfg.mask) == (cfg.map & cfg.mask)));
endmodule

// File: tb/alt_remap_top_test.sv
module alt_remap_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        warm_rst_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [31:0] addr_i = '0;
  logic        hit_o;
  logic [31:0] addr_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  alt_remap_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .warm_rst_i(warm_rst_i),
    .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .addr_i(addr_i), .hit_o(hit_o), .addr_o(addr_o)
  );

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] mask;
    logic [15:0] map;
    logic [31:0] addr;
    logic        hit;
    logic [31:0] xaddr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{16'h1234, 16'hFFFF, 16'hABCD, 32'h1234_5678, 1'b1, 32'hABCD_5678},
    '{16'h1234, 16'hFFFF, 16'hABCD, 32'h1235_5678, 1'b0, 32'h1235_5678},
    '{16'h8000, 16'hF000, 16'h2000, 32'h8ABC_0011, 1'b1, 32'h2ABC_0011},
    '{16'h8000, 16'hF000, 16'h2000, 32'h9ABC_0011, 1'b0, 32'h9ABC_0011},
    '{16'h0000, 16'h0000, 16'hFFFF, 32'h0000_0001, 1'b0, 32'h0000_0001},
    '{16'h0012, 16'h00FF, 16'h0034, 32'hEE12_FFFF, 1'b1, 32'hEE34_FFFF},
    '{16'h8001, 16'h8001, 16'h0000, 32'hFFFF_0000, 1'b1, 32'h7FFE_0000},
    '{16'h8001, 16'h8001, 16'h0000, 32'h7FFF_1234, 1'b0, 32'h7FFF_1234}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    reg_sel_i = sel;
    #1 chk(req, reg_rdata_o, exp);
  endtask

  task automatic cfg(input logic [15:0] b, input logic [15:0] m, input logic [15:0] p);
    wr(2'd0, {b, 16'h0});
    wr(2'd1, {m, 16'h0});
    wr(2'd2, {p, 16'h0});
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R6: reset state
    rd(2'd0, 32'h0, "R6 base cold");
    rd(2'd1, 32'h0, "R6 mask cold");
    rd(2'd2, 32'h0, "R6 map cold");
    rst_ni = 1'b1;
    addr_i = 32'h0000_0000;
    #1 chk("R2 reset mask zero no hit", {31'h0, hit_o}, 32'h0);

    // R1 R2 R3 R4: vector walk
    for (int i = 0; i < NV; i++) begin
      cfg(VEC[i].base, VEC[i].mask, VEC[i].map);
      @(negedge clk_i);
      addr_i = VEC[i].addr;
      #1;
      chk($sformatf("R1 hit vec%0d", i), {31'h0, hit_o}, {31'h0, VEC[i].hit});
      chk($sformatf("R3 R4 addr vec%0d", i), addr_o, VEC[i].xaddr);
    end

    // R9: combinational response without a clock edge
    cfg(16'h4000, 16'hC000, 16'h0000);
    @(negedge clk_i);
    addr_i = 32'h4000_0000;
    #1 chk("R9 immediate hit", {31'h0, hit_o}, 32'h1);
    addr_i = 32'h8000_0000;
    #1 chk("R9 immediate miss", {31'h0, hit_o}, 32'h0);
    chk("R9 immediate pass", addr_o, 32'h8000_0000);

    // R2: zero mask, base equal to address, still no hit
    cfg(16'hCAFE, 16'h0000, 16'h1111);
    @(negedge clk_i);
    addr_i = 32'hCAFE_0000;
    #1 chk("R2 zero mask disables", {31'h0, hit_o}, 32'h0);
    chk("R2 zero mask pass", addr_o, 32'hCAFE_0000);

    // R7 R8: readback format, low write bits discarded
    wr(2'd0, 32'h5A5A_FFFF);
    rd(2'd0, 32'h5A5A_0000, "R7 R8 base readback");
    wr(2'd2, 32'h0F0F_1234);
    rd(2'd2, 32'h0F0F_0000, "R7 map readback");
    wr(2'd1, 32'h00F0_0001);
    rd(2'd1, 32'h00F0_0000, "R7 mask readback");

    // R8: unused select reads zero, write has no effect
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R8 unused reads zero");
    rd(2'd0, 32'h5A5A_0000, "R8 base untouched");
    rd(2'd1, 32'h00F0_0000, "R8 mask untouched");
    rd(2'd2, 32'h0F0F_0000, "R8 map untouched");

    // R5: warm reset retains fields and blocks writes
    @(negedge clk_i);
    warm_rst_i = 1'b1;
    reg_sel_i = 2'd1; reg_wdata_i = 32'h0000_0000; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_sel_i = 2'd0; reg_wdata_i = 32'h1111_0000;
    @(negedge clk_i);
    reg_we_i = 1'b0; warm_rst_i = 1'b0;
    rd(2'd0, 32'h5A5A_0000, "R5 base kept");
    rd(2'd1, 32'h00F0_0000, "R5 mask kept");
    rd(2'd2, 32'h0F0F_0000, "R5 map kept");
    addr_i = 32'h0050_ABCD;
    #1 chk("R5 window live after warm", addr_o, 32'h0000_ABCD);

    // R6: cold reset clears
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 rst_ni = 1'b1;
    rd(2'd0, 32'h0, "R6 base cleared");
    rd(2'd1, 32'h0, "R6 mask cleared");
    rd(2'd2, 32'h0, "R6 map cleared");
    #1 chk("R6 no hit after cold", {31'h0, hit_o}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule